// File: doc/BRIEF.md
# Hardware Return Address Stack

This block is a dedicated on-chip last-in, first-out store for return addresses and general 16-bit data. A processor core sends it push-class operations (subroutine call, explicit push, interrupt entry) and pop-class operations (return, return from interrupt, plain pop, and pop that also clears the in-service flag). The entries can only be reached through these operations. They have no address in program or data space.

A pointer register selects the current top entry. Its width is a parameter, and the depth is two to the power of that width. After reset the pointer holds the highest index. A push first moves the pointer up by one and then writes there, so the first push after reset lands in entry 0. A pop returns the entry under the pointer and then moves the pointer down by one. The pointer wraps in both directions without raising any flag, so an overflow silently overwrites the oldest data.

Data enters on a valid/ready stream. `push_ready` is always high, because a push always has a slot to write (on overflow it overwrites the oldest entry), so a push completes in the cycle where `push_valid` is sampled high. Data leaves on a second valid/ready stream. `pop_data` always shows the top entry. `pop_valid` is high unless a push is offered in the same cycle. A pop completes in a cycle where both `pop_valid` and `pop_ready` are high. The consumer may hold `pop_ready` low for as long as it likes, and the stack stays unchanged.

Top module: `ret_stack`

## Requirements
- R1: The stack has 2^SP_W entries of DATA_W bits (defaults: 8 entries of 16 bits), and `sp_o` is SP_W bits wide.
- R2: After reset `sp_o` is all ones (7 for the default width), `clr_ins` is 0, `push_ready` is 1 and `pop_valid` is 1. Entry contents are not initialized.
- R3: A push completes when `push_valid` is high at a rising edge. The pointer becomes old+1 and `push_data` is written at that new index, so from the next cycle `pop_data` equals the pushed word. The first push after reset therefore fills entry 0.
- R4: `pop_data` always presents the entry at `sp_o`. A pop completes when `pop_valid` and `pop_ready` are both high at a rising edge, and the pointer becomes old-1 after the read.
- R5: A sequence of pushes followed by the same number of pops returns the words in reverse order and restores the original pointer.
- R6: A pop with `op_kind` 3'b111 (pop with flag clear) raises `clr_ins` for exactly the one cycle after the pop completes. Pops with 3'b100 (return), 3'b101 (return from interrupt) or 3'b110 (plain pop) never raise it.
- R7: Pushes with `op_kind` 3'b000 (call), 3'b001 (push) and 3'b010 (interrupt entry) move the pointer and store data identically. The pop-class kinds differ only in R6.
- R8: The pointer wraps modulo the depth. A push at the highest index goes to 0 and overwrites that entry. A pop at index 0 goes to the highest index. No flag is raised in either case.
- R9: If a push and a pop are requested in the same cycle, `pop_valid` is low, only the push takes effect, and `clr_ins` stays low.
- R10: In a cycle with no completed push or pop, the pointer and the presented top entry hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 3 | Operation kind: 000 call, 001 push, 010 interrupt entry, 100 return, 101 return from interrupt, 110 pop, 111 pop with flag clear |
| push_valid | input | 1 | Push word offered |
| push_ready | output | 1 | Push accepted (always 1) |
| push_data | input | DATA_W | Word to push |
| pop_valid | output | 1 | Top word available for popping |
| pop_ready | input | 1 | Consumer takes the top word |
| pop_data | output | DATA_W | Entry at the pointer |
| sp_o | output | SP_W | Current pointer value |
| clr_ins | output | 1 | One-cycle strobe that clears the in-service flag |

## Verification
Each push and pop is tried under every operation kind to show that only the flag-clearing pop changes the strobe. A push-three, pop-three run separates a correct last-in, first-out order from an off-by-one in the pre-increment or post-decrement. Nine pushes into eight entries, followed by nine pops, exercise wrap in both directions and show that the oldest word is lost and reread at index 0. A simultaneous push and pop request shows the push-priority rule, and idle cycles with the consumer stalled show that nothing moves without a handshake.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [2:0] {
    OPK_CALL  = 3'b000,
    OPK_PUSH  = 3'b001,
    OPK_INTR  = 3'b010,
    OPK_RSVD  = 3'b011,
    OPK_RET   = 3'b100,
    OPK_RETI  = 3'b101,
    OPK_POP   = 3'b110,
    OPK_POPCL = 3'b111
  } opk_e;

  // R6: only the flag-clearing pop raises the in-service clear strobe
  function automatic logic opk_clears_flag(opk_e k);
    return k == OPK_POPCL;
  endfunction

endpackage

// File: rtl/rstk_arbiter.sv
module rstk_arbiter
  import rstk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_kind,
  input  logic       push_valid,
  input  logic       pop_ready,
  output logic       push_ready,
  output logic       pop_valid,
  output logic       push_fire,
  output logic       pop_fire,
  output logic       clr_ins
);

  opk_e kind;
  logic clr_q;

  assign kind       = opk_e'(op_kind);
  assign push_ready = 1'b1;
  // R9: a pending push masks the pop side
  assign pop_valid  = ~push_valid;
  assign push_fire  = push_valid & push_ready;
  assign pop_fire   = pop_valid & pop_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= pop_fire & opk_clears_flag(kind);
  end

  assign clr_ins = clr_q;

  a_r9_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_fire, pop_fire}));

  a_r9_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_ready) |=> !clr_ins);

  a_r6_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ins |-> $past(pop_valid && pop_ready && op_kind == 3'b111));

  a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ins |=> (!clr_ins || $past(pop_fire)));

endmodule

// File: rtl/rstk_pointer.sv
module rstk_pointer #(
  parameter int SP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_fire,
  input  logic            pop_fire,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);

  localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};
  localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

  logic [SP_W-1:0] sp_q;

  // R8: plain modulo arithmetic, no overflow flag
  assign sp_up = sp_q + SP_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n)         sp_q <= SP_TOP;
    else if (push_fire) sp_q <= sp_up;
    else if (pop_fire)  sp_q <= sp_q - SP_ONE;
  end

  assign sp = sp_q;

  a_r3_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp == $past(sp) + SP_ONE);

  a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire) |=> sp == $past(sp) - SP_ONE);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_fire && !pop_fire) |=> $stable(sp));

  a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && sp == SP_TOP) |=> sp == '0);

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
  parameter int SP_W   = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SP_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SP_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << SP_W;

  // R2: contents are deliberately left without reset
  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_data;
  end

  assign rd_data = slots[rd_addr];

endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import rstk_pkg::*;
#(
  parameter int SP_W   = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_kind,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [DATA_W-1:0] pop_data,
  output logic [SP_W-1:0]   sp_o,
  output logic              clr_ins
);

  logic            push_fire;
  logic            pop_fire;
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_up;

  rstk_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_kind   (op_kind),
    .push_valid(push_valid),
    .pop_ready (pop_ready),
    .push_ready(push_ready),
    .pop_valid (pop_valid),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .clr_ins   (clr_ins)
  );

  rstk_pointer #(.SP_W(SP_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_fire(push_fire),
    .pop_fire (pop_fire),
    .sp       (sp),
    .sp_up    (sp_up)
  );

  // R3: the write goes to the incremented index; R4: the read comes from the current one
  rstk_store #(.SP_W(SP_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .wr_en  (push_fire),
    .wr_addr(sp_up),
    .wr_data(push_data),
    .rd_addr(sp),
    .rd_data(pop_data)
  );

  assign sp_o = sp;

  a_r3_top_is_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> pop_data == $past(push_data));

  a_r10_top_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !pop_ready) |=> $stable(pop_data));

  a_r2_push_ready: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready);

endmodule

// File: tb/ret_stack_tb_top.sv
module ret_stack_tb_top;

  localparam int SP_W   = 3;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << SP_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        op_kind = 3'b000;
  logic              push_valid = 1'b0;
  logic              push_ready;
  logic [DATA_W-1:0] push_data = '0;
  logic              pop_valid;
  logic              pop_ready = 1'b0;
  logic [DATA_W-1:0] pop_data;
  logic [SP_W-1:0]   sp_o;
  logic              clr_ins;

  int n_chk = 0;
  int n_bad = 0;
  logic [SP_W-1:0]   m_sp;
  logic [DATA_W-1:0] m_mem [DEPTH];

  ret_stack #(.SP_W(SP_W), .DATA_W(DATA_W)) dut_i (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [DATA_W-1:0] d, input logic [2:0] k, input string req);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; op_kind = k;
    @(negedge clk);
    push_valid = 1'b0;
    m_sp = m_sp + 1'b1;
    m_mem[m_sp] = d;
    chk(req, 32'(sp_o), 32'(m_sp));
    chk(req, 32'(pop_data), 32'(d));
    chk(req, 32'(clr_ins), 0);
  endtask

  task automatic do_pop(input logic [2:0] k, input string req);
    logic [DATA_W-1:0] got;
    @(negedge clk);
    pop_ready = 1'b1; op_kind = k;
    #0.5;
    chk(req, 32'(pop_valid), 1);
    got = pop_data;
    chk(req, 32'(got), 32'(m_mem[m_sp]));
    @(negedge clk);
    pop_ready = 1'b0;
    m_sp = m_sp - 1'b1;
    chk(req, 32'(sp_o), 32'(m_sp));
    chk("R6", 32'(clr_ins), (k == 3'b111) ? 1 : 0);
    @(negedge clk);
    chk("R6 single", 32'(clr_ins), 0);
  endtask

  task automatic t_reset();
    chk("R1 width", $bits(sp_o), SP_W);
    chk("R2 sp", 32'(sp_o), DEPTH - 1);
    chk("R2 clr", 32'(clr_ins), 0);
    chk("R2 push_ready", 32'(push_ready), 1);
    chk("R2 pop_valid", 32'(pop_valid), 1);
  endtask

  task automatic t_lifo();
    do_push(16'hA001, 3'b000, "R3 first push to 0");
    chk("R3 first idx", 32'(sp_o), 0);
    do_push(16'hB002, 3'b001, "R7 push kind");
    do_push(16'hC003, 3'b010, "R7 intr kind");
    do_pop(3'b100, "R5 ret");
    do_pop(3'b101, "R5 reti");
    do_pop(3'b110, "R4 pop");
    chk("R5 restored", 32'(sp_o), DEPTH - 1);
  endtask

  task automatic t_popclr();
    do_push(16'h1234, 3'b000, "R3");
    do_pop(3'b111, "R6 popclr");
  endtask

  task automatic t_wrap();
    for (int i = 0; i <= DEPTH; i++) do_push(16'h5000 + 16'(i), 3'b001, "R8 overflow");
    chk("R8 wrapped idx", 32'(sp_o), 0);
    chk("R8 overwrite", 32'(pop_data), 32'(16'h5000 + 16'(DEPTH)));
    for (int i = 0; i < DEPTH; i++) do_pop(3'b110, "R8 drain");
    chk("R8 at zero", 32'(sp_o), 0);
    do_pop(3'b110, "R8 underflow");
    chk("R8 underflow idx", 32'(sp_o), DEPTH - 1);
  endtask

  task automatic t_both();
    @(negedge clk);
    push_valid = 1'b1; pop_ready = 1'b1; push_data = 16'hBEEF; op_kind = 3'b111;
    #0.5;
    chk("R9 pop masked", 32'(pop_valid), 0);
    @(negedge clk);
    push_valid = 1'b0; pop_ready = 1'b0;
    m_sp = m_sp + 1'b1;
    m_mem[m_sp] = 16'hBEEF;
    chk("R9 push wins sp", 32'(sp_o), 32'(m_sp));
    chk("R9 push wins data", 32'(pop_data), 32'hBEEF);
    chk("R9 no clr", 32'(clr_ins), 0);
  endtask

  task automatic t_idle();
    logic [DATA_W-1:0] d0;
    d0 = pop_data;
    op_kind = 3'b111;
    repeat (5) @(negedge clk);
    chk("R10 sp hold", 32'(sp_o), 32'(m_sp));
    chk("R10 top hold", 32'(pop_data), 32'(d0));
    chk("R10 no clr", 32'(clr_ins), 0);
  endtask

  initial begin
    m_sp = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lifo();
    t_popclr();
    t_wrap();
    t_both();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule